// File: doc/BRIEF.md
# Dual Two-Phase Timer with Watchdog Reset

This peripheral holds two independent down-counting timers behind a small 32-bit register port (word address, write strobe, write data, read data). The period of each timer is split into a low phase and a high phase, each with its own programmed length, so the timer output forms a square or PWM-like waveform. The period is the sum of the two lengths. A timer reloads by itself at the end of every period and emits a one-cycle interrupt strobe for that reload.

Timer 0 has a second use. Writing 0xFF into the low byte of its low-phase length register turns it into a watchdog. Bits [15:8] of that register, multiplied by four, set the watchdog length in clock ticks. When the watchdog runs out it raises a reset request. The request stays high until the peripheral itself is reset. Software programs a timer in three steps: clear its enable bit, write its lengths, then set the enable bit again, which starts a fresh period.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset, every output is 0, both timers are idle and every register reads 0.
- R2: Word offsets: 0x00 control (bit 0 enables timer 0, bit 1 enables timer 1), 0x04 timer 1 low-phase length, 0x08 timer 0 low-phase length, 0x0C timer 1 high-phase length, 0x10 timer 0 high-phase length. The lower 16 bits of a length write are stored. An idle timer reads back what was written.
- R3: A control write that keeps a timer's enable bit at 1 leaves that timer's count, phase and output unchanged, whatever happens to the other bit.
- R4: A running timer repeats periods of (low length + high length) ticks. Its output is 0 during the low phase and 1 during the high phase.
- R5: At every reload, a normal-mode timer drives its interrupt bit high for one cycle. The pulse comes in the cycle after the last tick of the period.
- R6: A phase of length 0 is skipped. A timer with both lengths 0 stays idle when enabled, with output 0 and no interrupt.
- R7: While a phase runs, its register reads back the ticks left in that phase. While the high phase runs, the low-phase register reads 0.
- R8: A 0-to-1 enable transition starts a new period from the lengths held at that moment. Length writes made while the timer runs take effect at its next reload.
- R9: Clearing an enable bit stops that timer in the next cycle, with output 0.
- R10: When timer 0's low-phase register holds 0xFF in bits [7:0], timer 0 is a watchdog of (bits [15:8] × 4) ticks. With any other low byte it is a normal timer. A watchdog length of 0 never expires.
- R11: When the watchdog expires, the reset request rises and stays high until rst_n. Timer 0 then raises no interrupt and drives output 0.
- R12: Reads of offsets 0x14 to 0x1C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address, word aligned |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, same cycle |
| tmrOut | output | 2 | Phase output per timer, high in the high phase |
| tmrIrq | output | 2 | One-cycle reload strobe per timer |
| wdogRst | output | 1 | Sticky reset request from the timer 0 watchdog |

## Verification
The assertions assume that the bus makes at most one write per cycle and that addresses are word aligned. The single-pulse property of the interrupt holds only when a period lasts at least two ticks. With a one-tick period the strobe stays high on every cycle, so no assertion claims a gap after each pulse. The stimulus keeps every period at two ticks or more. It writes lengths while a timer is running and while it is stopped, and it leaves every timer idle before switching timer 0 into or out of watchdog mode. A behavioural model in the bench is compared against every output and the read data on every cycle.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  localparam int NUM_TMR = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_WDOG = 2'd3
  } phase_e;

  // control-to-datapath strobes, one bit per timer
  typedef struct packed {
    logic [NUM_TMR-1:0] start;
    logic [NUM_TMR-1:0] stop;
  } tmrStrobe_t;

endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
  import dpt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WD_SHIFT = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWe,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  input  logic [NUM_TMR-1:0][1:0]         phase,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt,
  output tmrStrobe_t                      strobe,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   lowLen,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   highLen,
  output logic                            wdMode,
  output logic [CNT_W-1:0]                wdLen
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int IDX_CTRL = 0;
  localparam int IDX_LO1  = 1;
  localparam int IDX_LO0  = 2;
  localparam int IDX_HI1  = 3;
  localparam int IDX_HI0  = 4;

  logic [IDX_W-1:0]         wIdx;
  logic                     ctrlWr;
  logic [NUM_TMR-1:0]       enReg;
  logic [NUM_TMR-1:0][CNT_W-1:0] rdLow;
  logic [NUM_TMR-1:0][CNT_W-1:0] rdHigh;

  assign wIdx   = busAddr[ADDR_W-1:2];
  assign ctrlWr = busWe && (wIdx == IDX_W'(IDX_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n)      enReg <= '0;
    else if (ctrlWr) enReg <= busWdata[NUM_TMR-1:0];
  end

  // start only on a 0->1 edge; a bit kept at 1 leaves its timer alone
  assign strobe.start = ctrlWr ? (busWdata[NUM_TMR-1:0] & ~enReg) : '0;
  assign strobe.stop  = ctrlWr ? ~busWdata[NUM_TMR-1:0] : '0;

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    localparam int LO_IDX = (gi == 0) ? IDX_LO0 : IDX_LO1;
    localparam int HI_IDX = (gi == 0) ? IDX_HI0 : IDX_HI1;
    logic [CNT_W-1:0] lowQ;
    logic [CNT_W-1:0] highQ;
    phase_e           ph;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lowQ  <= '0;
        highQ <= '0;
      end else if (busWe) begin
        if (wIdx == IDX_W'(LO_IDX)) lowQ  <= busWdata[CNT_W-1:0];
        if (wIdx == IDX_W'(HI_IDX)) highQ <= busWdata[CNT_W-1:0];
      end
    end

    assign ph          = phase_e'(phase[gi]);
    assign lowLen[gi]  = lowQ;
    assign highLen[gi] = highQ;

    always_comb begin
      case (ph)
        PH_LOW:  rdLow[gi] = cnt[gi];
        PH_HIGH: rdLow[gi] = '0;
        default: rdLow[gi] = lowQ;
      endcase
      rdHigh[gi] = (ph == PH_HIGH) ? cnt[gi] : highQ;
    end
  end

  assign wdMode = (lowLen[0][7:0] == 8'hFF);
  assign wdLen  = CNT_W'(lowLen[0][15:8]) << WD_SHIFT;

  always_comb begin
    case (wIdx)
      IDX_W'(IDX_CTRL): busRdata = DATA_W'(enReg);
      IDX_W'(IDX_LO1):  busRdata = DATA_W'(rdLow[1]);
      IDX_W'(IDX_LO0):  busRdata = DATA_W'(rdLow[0]);
      IDX_W'(IDX_HI1):  busRdata = DATA_W'(rdHigh[1]);
      IDX_W'(IDX_HI0):  busRdata = DATA_W'(rdHigh[0]);
      default:          busRdata = '0;
    endcase
  end

endmodule

// File: rtl/dpt_core.sv
module dpt_core
  import dpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  tmrStrobe_t                      strobe,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   lowLen,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   highLen,
  input  logic                            wdMode,
  input  logic [CNT_W-1:0]                wdLen,
  output logic [NUM_TMR-1:0][1:0]         phase,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cnt,
  output logic [NUM_TMR-1:0]              tmrOut,
  output logic [NUM_TMR-1:0]              tmrIrq,
  output logic                            wdogRst
);

  logic [NUM_TMR-1:0] expireVec;
  logic               wdogQ;

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    logic             isWd;
    phase_e           phQ, phN, loadPh;
    logic [CNT_W-1:0] cntQ, cntN, loadCnt;
    logic             reload, expire, irqQ;

    // only timer 0 can become a watchdog
    if (gi == 0) begin : g_wd
      assign isWd = wdMode;
    end else begin : g_nowd
      assign isWd = 1'b0;
    end

    // value a fresh period starts from; empty phases are skipped
    always_comb begin
      if (isWd) begin
        loadPh  = (wdLen != '0) ? PH_WDOG : PH_IDLE;
        loadCnt = wdLen;
      end else if (lowLen[gi] != '0) begin
        loadPh  = PH_LOW;
        loadCnt = lowLen[gi];
      end else if (highLen[gi] != '0) begin
        loadPh  = PH_HIGH;
        loadCnt = highLen[gi];
      end else begin
        loadPh  = PH_IDLE;
        loadCnt = '0;
      end
    end

    always_comb begin
      phN    = phQ;
      cntN   = cntQ;
      reload = 1'b0;
      expire = 1'b0;
      if (strobe.stop[gi]) begin
        phN  = PH_IDLE;
        cntN = '0;
      end else if (strobe.start[gi]) begin
        phN  = loadPh;
        cntN = loadCnt;
      end else begin
        case (phQ)
          PH_LOW: begin
            if (cntQ > CNT_W'(1)) begin
              cntN = cntQ - CNT_W'(1);
            end else if (highLen[gi] != '0) begin
              phN  = PH_HIGH;
              cntN = highLen[gi];
            end else begin
              reload = 1'b1;
              phN    = loadPh;
              cntN   = loadCnt;
            end
          end
          PH_HIGH: begin
            if (cntQ > CNT_W'(1)) begin
              cntN = cntQ - CNT_W'(1);
            end else begin
              reload = 1'b1;
              phN    = loadPh;
              cntN   = loadCnt;
            end
          end
          PH_WDOG: begin
            if (cntQ > CNT_W'(1)) begin
              cntN = cntQ - CNT_W'(1);
            end else begin
              expire = 1'b1;
              phN    = PH_IDLE;
              cntN   = '0;
            end
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phQ  <= PH_IDLE;
        cntQ <= '0;
        irqQ <= 1'b0;
      end else begin
        phQ  <= phN;
        cntQ <= cntN;
        irqQ <= reload && !isWd;
      end
    end

    assign phase[gi]     = phQ;
    assign cnt[gi]       = cntQ;
    assign tmrOut[gi]    = (phQ == PH_HIGH);
    assign tmrIrq[gi]    = irqQ;
    assign expireVec[gi] = expire;

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.stop[gi] |=> (phase_e'(phase[gi]) == PH_IDLE));

    // R4
    live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_e'(phase[gi]) != PH_IDLE) |-> (cnt[gi] != '0));

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmrIrq[gi] |-> ($past(phase[gi]) != 2'(PH_IDLE)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wdogQ <= 1'b0;
    else        wdogQ <= wdogQ | (|expireVec);
  end
  assign wdogRst = wdogQ;

  // R11
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdogRst |=> wdogRst);

  // R11
  wd_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmrIrq[0] |-> !$past(wdMode));

endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WD_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        tmrOut,
  output logic [1:0]        tmrIrq,
  output logic              wdogRst
);

  tmrStrobe_t                      strobe;
  logic [NUM_TMR-1:0][1:0]         phase;
  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt;
  logic [NUM_TMR-1:0][CNT_W-1:0]   lowLen;
  logic [NUM_TMR-1:0][CNT_W-1:0]   highLen;
  logic                            wdMode;
  logic [CNT_W-1:0]                wdLen;

  dpt_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WD_SHIFT(WD_SHIFT)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .phase(phase), .cnt(cnt), .strobe(strobe),
    .lowLen(lowLen), .highLen(highLen), .wdMode(wdMode), .wdLen(wdLen)
  );

  dpt_core #(
    .CNT_W(CNT_W)
  ) i_core (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .lowLen(lowLen), .highLen(highLen), .wdMode(wdMode), .wdLen(wdLen),
    .phase(phase), .cnt(cnt), .tmrOut(tmrOut), .tmrIrq(tmrIrq), .wdogRst(wdogRst)
  );

endmodule

// File: tb/test_dual_phase_timer.sv
module test_dual_phase_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  tmrOut, tmrIrq;
  logic        wdogRst;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  dual_phase_timer i_dual_phase_timer (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .tmrOut(tmrOut), .tmrIrq(tmrIrq), .wdogRst(wdogRst)
  );

  // behavioural model: phase 0 idle, 1 low, 2 high, 3 watchdog
  int  mEn[2], mPh[2], mCnt[2], mLo[2], mHi[2];
  bit  mIrq[2];
  bit  mRst;

  function automatic bit wdOn();
    return (mLo[0] & 'hFF) == 'hFF;
  endfunction

  function automatic void mLoad(int i);
    if (i == 0 && wdOn()) begin
      mCnt[i] = ((mLo[0] >> 8) & 'hFF) * 4;
      mPh[i]  = (mCnt[i] != 0) ? 3 : 0;
    end else if (mLo[i] != 0) begin mPh[i] = 1; mCnt[i] = mLo[i]; end
    else if (mHi[i] != 0)     begin mPh[i] = 2; mCnt[i] = mHi[i]; end
    else                      begin mPh[i] = 0; mCnt[i] = 0; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        mEn[i] = 0; mPh[i] = 0; mCnt[i] = 0; mLo[i] = 0; mHi[i] = 0; mIrq[i] = 0;
      end
      mRst = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit wr0, st, sp;
        wr0 = busWe && busAddr == 5'h00;
        st  = wr0 && busWdata[i] && mEn[i] == 0;
        sp  = wr0 && !busWdata[i];
        mIrq[i] = 0;
        if (sp) begin mPh[i] = 0; mCnt[i] = 0; end
        else if (st) mLoad(i);
        else if (mPh[i] != 0) begin
          if (mCnt[i] > 1) mCnt[i]--;
          else if (mPh[i] == 3) begin mRst = 1; mPh[i] = 0; mCnt[i] = 0; end
          else if (mPh[i] == 1 && mHi[i] != 0) begin mPh[i] = 2; mCnt[i] = mHi[i]; end
          else begin
            mIrq[i] = !(i == 0 && wdOn());
            mLoad(i);
          end
        end
      end
      if (busWe) begin
        case (busAddr)
          5'h00: begin mEn[0] = busWdata[0]; mEn[1] = busWdata[1]; end
          5'h04: mLo[1] = busWdata & 'hFFFF;
          5'h08: mLo[0] = busWdata & 'hFFFF;
          5'h0C: mHi[1] = busWdata & 'hFFFF;
          5'h10: mHi[0] = busWdata & 'hFFFF;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRd(logic [4:0] a);
    case (a)
      5'h00: return 32'(mEn[0] + 2 * mEn[1]);
      5'h04: return (mPh[1] == 1) ? 32'(mCnt[1]) : (mPh[1] == 2) ? 32'd0 : 32'(mLo[1]);
      5'h08: return (mPh[0] == 1) ? 32'(mCnt[0]) : (mPh[0] == 2) ? 32'd0 : 32'(mLo[0]);
      5'h0C: return (mPh[1] == 2) ? 32'(mCnt[1]) : 32'(mHi[1]);
      5'h10: return (mPh[0] == 2) ? 32'(mCnt[0]) : 32'(mHi[0]);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare everything against the model, then drive the next cycle
  task automatic cyc(bit we, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    check(curReq, "busRdata", busRdata, expRd(busAddr));
    for (int i = 0; i < 2; i++) begin
      check(curReq, "tmrOut", 32'(tmrOut[i]), 32'(mPh[i] == 2));
      check(curReq, "tmrIrq", 32'(tmrIrq[i]), 32'(mIrq[i]));
    end
    check(curReq, "wdogRst", 32'(wdogRst), 32'(mRst));
    busWe = we; busAddr = a; busWdata = d;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(int n, logic [4:0] a);
    for (int k = 0; k < n; k++) cyc(1'b0, a, 32'd0);
  endtask

  task automatic peek(string req, logic [4:0] a, logic [31:0] exp);
    cyc(1'b0, a, 32'd0);
    #1;
    check(req, "literal read", busRdata, exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3, 5'h00);
    rst_n = 1'b1;
    // R1: reset state
    curReq = "R1";
    peek("R1", 5'h00, 32'd0);
    peek("R1", 5'h08, 32'd0);
    peek("R1", 5'h10, 32'd0);
    #1; check("R1", "outputs", {27'd0, tmrOut, tmrIrq, wdogRst}, 32'd0);

    // R2: register map and idle readback
    curReq = "R2";
    wr(5'h04, 32'hABCD_0003);
    wr(5'h0C, 32'd2);
    wr(5'h08, 32'd4);
    wr(5'h10, 32'd5);
    peek("R2", 5'h04, 32'h0003);
    peek("R2", 5'h0C, 32'd2);
    peek("R2", 5'h08, 32'd4);
    peek("R2", 5'h10, 32'd5);

    // R12: unmapped offsets
    curReq = "R12";
    peek("R12", 5'h14, 32'd0);
    peek("R12", 5'h1C, 32'd0);

    // R4 R5 R7: timer 1 alone, reading both phase registers
    curReq = "R4";
    wr(5'h00, 32'd2);
    idle(12, 5'h04);
    curReq = "R7";
    idle(12, 5'h0C);
    curReq = "R5";
    idle(8, 5'h00);

    // R3: enable timer 0 with a read-modify-write, timer 1 undisturbed
    curReq = "R3";
    wr(5'h00, 32'd3);
    idle(20, 5'h08);
    // R9: stop timer 1 only
    curReq = "R9";
    wr(5'h00, 32'd1);
    idle(2, 5'h04);
    #1; check("R9", "tmrOut[1]", 32'(tmrOut[1]), 32'd0);
    idle(10, 5'h10);

    // R8: write while running, applies at next reload; restart is fresh
    curReq = "R8";
    wr(5'h08, 32'd1);
    idle(16, 5'h08);
    wr(5'h00, 32'd0);
    wr(5'h00, 32'd1);
    idle(10, 5'h10);

    // R6: zero low phase skipped; all-zero stays idle
    curReq = "R6";
    wr(5'h00, 32'd0);
    wr(5'h04, 32'd0);
    wr(5'h0C, 32'd3);
    wr(5'h00, 32'd2);
    idle(10, 5'h0C);
    wr(5'h00, 32'd0);
    wr(5'h0C, 32'd0);
    wr(5'h00, 32'd2);
    idle(6, 5'h04);
    #1; check("R6", "idle out/irq", {30'd0, tmrOut[1], tmrIrq[1]}, 32'd0);
    wr(5'h04, 32'd2);
    wr(5'h00, 32'd0);
    wr(5'h00, 32'd2);
    idle(8, 5'h04);

    // R10: switch timer 0 to watchdog, 10*4 = 40 ticks
    curReq = "R10";
    wr(5'h00, 32'd0);
    wr(5'h08, 32'h0000_0AFF);
    peek("R10", 5'h08, 32'h0AFF);
    wr(5'h00, 32'd1);
    idle(30, 5'h10);
    #1; check("R10", "no early reset", 32'(wdogRst), 32'd0);
    curReq = "R11";
    idle(15, 5'h08);
    #1; check("R11", "wdogRst set", 32'(wdogRst), 32'd1);
    wr(5'h00, 32'd0);
    idle(5, 5'h00);
    #1; check("R11", "wdogRst sticky", 32'(wdogRst), 32'd1);
    // R10: a zero watchdog length never expires
    curReq = "R10";
    rst_n = 1'b0;
    idle(2, 5'h00);
    rst_n = 1'b1;
    wr(5'h08, 32'h0000_00FF);
    wr(5'h00, 32'd1);
    idle(20, 5'h08);
    #1; check("R10", "zero-length watchdog", 32'(wdogRst), 32'd0);
    // R10: any other low byte means normal mode again
    wr(5'h00, 32'd0);
    wr(5'h08, 32'h0000_0A03);
    wr(5'h10, 32'd2);
    wr(5'h00, 32'd1);
    idle(12, 5'h10);
    idle(8, 5'h08);

    busWe = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule